// File: doc/BRIEF.md
# Tile Background Pixel Generator

This block turns a screen coordinate into one pixel of a character-cell background layer. The layer is a grid of 8x8-pixel tiles that is 32 rows tall and either 40 or 80 columns wide. Each tile pattern stores sixteen-colour pixels packed two to a byte. A video timing source presents one coordinate per cycle. The block applies a horizontal and a vertical scroll. It then fetches the map entry for the cell under the scrolled position. From that entry it finds the tile number and its attribute byte, and fetches the pattern byte that holds the pixel. A fixed number of cycles later it emits an 8-bit palette index, a transparency flag and a below-other-layer flag.

Both fetches use synchronous read ports with one cycle of latency. The map port returns two adjacent bytes, so a tile number and its attribute arrive together. When the map carries no attribute bytes, every tile takes its attribute from one default attribute input. Mode inputs select the column count, whether attributes are present, and whether the map addresses 256 or 512 tiles. Two 6-bit base inputs place the map and the pattern area in the 16 KB memory, in steps of 256 bytes. The palette lookup, the register bus and timing generation sit outside the block.

Top module: `tilemap_pixel_gen`

## Requirements
- R1: While reset is held, and after it is released until the first pixel completes, `out_valid` is 0. The stored transparent index comes out of reset as 0xF.
- R2: A coordinate presented with `pix_valid` high produces `out_valid` high exactly three clock edges later, with the matching outputs. A new coordinate may be presented every cycle.
- R3: The map read address is (map_base × 256 + (row × C + column) × S) modulo 16384. C is 40 when `cols80`=0 and 80 when `cols80`=1. S is 2 when `attr_off`=0 and 1 when `attr_off`=1. Row and column are the scrolled y and x divided by 8.
- R4: The scrolled x is (pix_x + scroll_x) modulo 320 when `cols80`=0, and modulo 640 when `cols80`=1, for any 10-bit scroll_x.
- R5: The scrolled y is (pix_y + scroll_y) modulo 256.
- R6: The attribute is `map_data[15:8]` when `attr_off`=0 and `def_attr` when `attr_off`=1. The tile number is `map_data[7:0]`. When `tiles512`=1, attribute bit 0 becomes tile-number bit 8 and `out_below` is 0. When `tiles512`=0, `out_below` equals attribute bit 0.
- R7: The pattern read address is (tile_base × 256 + tile × 32 + r × 4 + c / 2) modulo 16384. Here r and c are the in-tile row and column after transformation. Even c selects bits 7-4 of the pattern byte and odd c selects bits 3-0.
- R8: Attribute bit 1 (rotate) swaps the in-tile row and column first. After that, bit 3 (mirror X) replaces c with 7−c and bit 2 (mirror Y) replaces r with 7−r.
- R9: `out_index` is attribute bits 7-4 in its bits 7-4, with the selected 4-bit pixel value in bits 3-0.
- R10: `out_transparent` is 1 exactly when the 4-bit pixel value equals the stored transparent index. A cycle with `trans_we`=1 loads `trans_wdata` into the stored index, and the index does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cols80 | input | 1 | 1 = 80 columns, 0 = 40 columns |
| attr_off | input | 1 | 1 = map holds tile numbers only |
| tiles512 | input | 1 | 1 = attribute bit 0 extends the tile number |
| map_base | input | 6 | Map start, in 256-byte steps |
| tile_base | input | 6 | Pattern area start, in 256-byte steps |
| def_attr | input | 8 | Attribute used when `attr_off`=1 |
| scroll_x | input | 10 | Horizontal scroll |
| scroll_y | input | 8 | Vertical scroll |
| trans_we | input | 1 | Load strobe for the transparent index |
| trans_wdata | input | 4 | New transparent index |
| pix_valid | input | 1 | Coordinate present this cycle |
| pix_x | input | 10 | Screen x, below the active width |
| pix_y | input | 8 | Screen y |
| map_rd | output | 1 | Map read strobe |
| map_addr | output | 14 | Map read address |
| map_data | input | 16 | Bytes at map_addr (7:0) and map_addr+1 (15:8), one cycle after the read |
| pat_rd | output | 1 | Pattern read strobe |
| pat_addr | output | 14 | Pattern read address |
| pat_data | input | 8 | Byte at pat_addr, one cycle after the read |
| out_valid | output | 1 | Pixel outputs valid |
| out_index | output | 8 | Palette index |
| out_transparent | output | 1 | Pixel equals the transparent index |
| out_below | output | 1 | Tile is drawn under the other layer |

## Verification
The assertions assume that `pix_x` stays below the active width of the selected mode. They also assume that the mode, base, default-attribute and scroll inputs do not change while a pixel is still in the pipeline, and that the transparent index is rewritten only when no pixel is about to complete. The stimulus follows these rules. Each coordinate is chosen inside the active width. Configuration is changed only on the cycle that presents a new coordinate, and after the previous pixel has left the pipeline. The index write task runs only when the pipeline is empty. The back-to-back run holds one configuration for its whole length.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef struct packed {
    logic [3:0] pal;
    logic       mirror_x;
    logic       mirror_y;
    logic       rotate;
    logic       low_bit;
  } tile_attr_t;
endpackage

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int ADDR_W      = 14,
  parameter int BASE_W      = 6,
  parameter int XW          = 10,
  parameter int YW          = 8,
  parameter int NARROW_COLS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [XW-1:0]     pix_x,
  input  logic [YW-1:0]     pix_y,
  input  logic [XW-1:0]     scroll_x,
  input  logic [YW-1:0]     scroll_y,
  input  logic              cols80,
  input  logic              attr_off,
  input  logic [BASE_W-1:0] map_base,
  output logic              map_rd,
  output logic [ADDR_W-1:0] map_addr,
  output logic              s1_valid,
  output logic [2:0]        s1_fx,
  output logic [2:0]        s1_fy
);
  localparam int CELL_W     = 3;
  localparam int NARROW_PX  = NARROW_COLS * 8;
  localparam int WIDE_COLS  = 2 * NARROW_COLS;
  localparam int WIDE_PX    = WIDE_COLS * 8;
  localparam int COL_W      = $clog2(WIDE_COLS);
  localparam int ROW_W      = YW - CELL_W;
  localparam int ENT_W      = COL_W + ROW_W;
  localparam int SUM_W      = XW + 1;
  localparam int BASE_SH    = ADDR_W - BASE_W;
  localparam int WRAP_STEPS = (NARROW_PX - 1 + (2**XW) - 1) / NARROW_PX;

  logic [SUM_W-1:0]  span;
  logic [SUM_W-1:0]  sx_acc;
  logic [YW-1:0]     sy;
  logic [COL_W-1:0]  col;
  logic [COL_W-1:0]  ncols;
  logic [ROW_W-1:0]  row;
  logic [ENT_W-1:0]  entry;
  logic [ADDR_W-1:0] offs;
  logic [2:0]        fx_d;
  logic [2:0]        fy_d;

  // Scroll, wrap and map-entry address for the presented coordinate.
  always_comb begin
    span   = cols80 ? SUM_W'(WIDE_PX) : SUM_W'(NARROW_PX);
    sx_acc = SUM_W'(pix_x) + SUM_W'(scroll_x);
    for (int i = 0; i < WRAP_STEPS; i++) begin
      if (sx_acc >= span) sx_acc = sx_acc - span;
    end
    sy       = pix_y + scroll_y;
    col      = sx_acc[CELL_W +: COL_W];
    row      = sy[YW-1:CELL_W];
    ncols    = cols80 ? COL_W'(WIDE_COLS) : COL_W'(NARROW_COLS);
    entry    = ENT_W'(row) * ENT_W'(ncols) + ENT_W'(col);
    offs     = attr_off ? ADDR_W'(entry) : ADDR_W'({entry, 1'b0});
    map_addr = {map_base, {BASE_SH{1'b0}}} + offs;
    fx_d     = sx_acc[CELL_W-1:0];
    fy_d     = sy[CELL_W-1:0];
  end

  assign map_rd = pix_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= pix_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_fx <= '0;
      s1_fy <= '0;
    end else if (pix_valid) begin
      s1_fx <= fx_d;
      s1_fy <= fy_d;
    end
  end

  // Input assumption: the coordinate lies inside the active width.
  assert_x_in_screen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (SUM_W'(pix_x) < span));

  assert_xwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (sx_acc < span));

  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (col < ncols));
endmodule

// File: rtl/tile_attr_decode.sv
module tile_attr_decode
  import tile_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BASE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [2:0]        s1_fx,
  input  logic [2:0]        s1_fy,
  input  logic [15:0]       map_data,
  input  logic              attr_off,
  input  logic              tiles512,
  input  logic [7:0]        def_attr,
  input  logic [BASE_W-1:0] tile_base,
  output logic              pat_rd,
  output logic [ADDR_W-1:0] pat_addr,
  output logic              s2_valid,
  output logic [3:0]        s2_pal,
  output logic              s2_below,
  output logic              s2_lo
);
  localparam int TILE_W  = 9;
  localparam int PAT_SH  = 5;
  localparam int BASE_SH = ADDR_W - BASE_W;

  tile_attr_t        attr;
  logic [TILE_W-1:0] tile;
  logic              below_d;
  logic [2:0]        c0;
  logic [2:0]        r0;
  logic [2:0]        c;
  logic [2:0]        r;

  // Attribute selection, then rotate, then mirror, then pattern address.
  always_comb begin
    attr     = attr_off ? tile_attr_t'(def_attr) : tile_attr_t'(map_data[15:8]);
    tile     = {tiles512 & attr.low_bit, map_data[7:0]};
    below_d  = ~tiles512 & attr.low_bit;
    c0       = attr.rotate ? s1_fy : s1_fx;
    r0       = attr.rotate ? s1_fx : s1_fy;
    c        = attr.mirror_x ? ~c0 : c0;
    r        = attr.mirror_y ? ~r0 : r0;
    pat_addr = {tile_base, {BASE_SH{1'b0}}}
             + ADDR_W'({tile, {PAT_SH{1'b0}}})
             + ADDR_W'({r, c[2:1]});
  end

  assign pat_rd = s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_pal   <= '0;
      s2_below <= 1'b0;
      s2_lo    <= 1'b0;
    end else if (s1_valid) begin
      s2_pal   <= attr.pal;
      s2_below <= below_d;
      s2_lo    <= c[0];
    end
  end
endmodule

// File: rtl/tile_pixel_out.sv
module tile_pixel_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s2_valid,
  input  logic [3:0] s2_pal,
  input  logic       s2_below,
  input  logic       s2_lo,
  input  logic [7:0] pat_data,
  input  logic [3:0] trans_idx,
  output logic       out_valid,
  output logic [7:0] out_index,
  output logic       out_transparent,
  output logic       out_below
);
  logic [3:0] nib;

  always_comb begin
    nib = s2_lo ? pat_data[3:0] : pat_data[7:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_index       <= '0;
      out_transparent <= 1'b0;
      out_below       <= 1'b0;
    end else if (s2_valid) begin
      out_index       <= {s2_pal, nib};
      out_transparent <= (nib == trans_idx);
      out_below       <= s2_below;
    end
  end
endmodule

// File: rtl/tilemap_pixel_gen.sv
module tilemap_pixel_gen #(
  parameter int ADDR_W      = 14,
  parameter int BASE_W      = 6,
  parameter int XW          = 10,
  parameter int YW          = 8,
  parameter int NARROW_COLS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cols80,
  input  logic              attr_off,
  input  logic              tiles512,
  input  logic [BASE_W-1:0] map_base,
  input  logic [BASE_W-1:0] tile_base,
  input  logic [7:0]        def_attr,
  input  logic [XW-1:0]     scroll_x,
  input  logic [YW-1:0]     scroll_y,
  input  logic              trans_we,
  input  logic [3:0]        trans_wdata,
  input  logic              pix_valid,
  input  logic [XW-1:0]     pix_x,
  input  logic [YW-1:0]     pix_y,
  output logic              map_rd,
  output logic [ADDR_W-1:0] map_addr,
  input  logic [15:0]       map_data,
  output logic              pat_rd,
  output logic [ADDR_W-1:0] pat_addr,
  input  logic [7:0]        pat_data,
  output logic              out_valid,
  output logic [7:0]        out_index,
  output logic              out_transparent,
  output logic              out_below
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_sync;
  logic                rst_sn;
  logic [3:0]          trans_q;
  logic [3:0]          trans_d;
  logic                s1_valid;
  logic [2:0]          s1_fx;
  logic [2:0]          s1_fy;
  logic                s2_valid;
  logic [3:0]          s2_pal;
  logic                s2_below;
  logic                s2_lo;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sn = rst_sync[SYNC_LEN-1];

  always_comb begin
    trans_d = trans_we ? trans_wdata : trans_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) trans_q <= 4'hF;
    else         trans_q <= trans_d;
  end

  tile_addr_gen #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .XW(XW), .YW(YW), .NARROW_COLS(NARROW_COLS)
  ) u_addr (
    .clk(clk), .rst_n(rst_sn), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .cols80(cols80), .attr_off(attr_off),
    .map_base(map_base), .map_rd(map_rd), .map_addr(map_addr),
    .s1_valid(s1_valid), .s1_fx(s1_fx), .s1_fy(s1_fy)
  );

  tile_attr_decode #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W)
  ) u_attr (
    .clk(clk), .rst_n(rst_sn), .s1_valid(s1_valid), .s1_fx(s1_fx), .s1_fy(s1_fy),
    .map_data(map_data), .attr_off(attr_off), .tiles512(tiles512), .def_attr(def_attr),
    .tile_base(tile_base), .pat_rd(pat_rd), .pat_addr(pat_addr),
    .s2_valid(s2_valid), .s2_pal(s2_pal), .s2_below(s2_below), .s2_lo(s2_lo)
  );

  tile_pixel_out u_out (
    .clk(clk), .rst_n(rst_sn), .s2_valid(s2_valid), .s2_pal(s2_pal),
    .s2_below(s2_below), .s2_lo(s2_lo), .pat_data(pat_data), .trans_idx(trans_q),
    .out_valid(out_valid), .out_index(out_index),
    .out_transparent(out_transparent), .out_below(out_below)
  );

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    pix_valid |-> ##3 out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !pix_valid |-> ##3 !out_valid);

  assert_trans_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !trans_we |=> $stable(trans_q));

  assert_trans_load_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    trans_we |=> (trans_q == $past(trans_wdata)));
endmodule

// File: tb/tilemap_pixel_gen_test.sv
`timescale 1ns/1ps
module tilemap_pixel_gen_test;
  typedef struct packed {
    logic [9:0] x;
    logic [7:0] y;
    logic [9:0] ox;
    logic [7:0] oy;
    logic       c80;
    logic       noat;
    logic       t512;
    logic [7:0] dat;
    logic [5:0] mb;
    logic [5:0] tb;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{10'd0,   8'd0,   10'd0,    8'd0,   1'b0, 1'b0, 1'b0, 8'h00, 6'h00, 6'h10}, // R3 R6 origin, 40 col
    '{10'd5,   8'd9,   10'd0,    8'd0,   1'b0, 1'b0, 1'b1, 8'h00, 6'h00, 6'h10}, // R6 512-tile
    '{10'd319, 8'd0,   10'd1,    8'd0,   1'b0, 1'b0, 1'b0, 8'h00, 6'h04, 6'h10}, // R4 wrap to 0
    '{10'd300, 8'd250, 10'd100,  8'd10,  1'b0, 1'b0, 1'b0, 8'h00, 6'h00, 6'h10}, // R4 R5 both wrap
    '{10'd639, 8'd255, 10'd1,    8'd1,   1'b1, 1'b0, 1'b0, 8'h00, 6'h00, 6'h20}, // R4 R5 80 col
    '{10'd100, 8'd40,  10'd1023, 8'd200, 1'b0, 1'b0, 1'b1, 8'h00, 6'h08, 6'h18}, // R4 large scroll
    '{10'd17,  8'd3,   10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 8'h2A, 6'h00, 6'h10}, // R8 rotate+mirror X
    '{10'd18,  8'd4,   10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 8'h36, 6'h00, 6'h10}, // R8 rotate+mirror Y
    '{10'd21,  8'd6,   10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 8'h5C, 6'h00, 6'h10}, // R8 mirror X+Y
    '{10'd22,  8'd7,   10'd0,    8'd0,   1'b1, 1'b1, 1'b1, 8'h01, 6'h00, 6'h10}, // R6 default bit0 as tile bit 8
    '{10'd23,  8'd7,   10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 8'h01, 6'h00, 6'h10}, // R6 default bit0 as below
    '{10'd400, 8'd100, 10'd250,  8'd0,   1'b1, 1'b0, 1'b1, 8'h00, 6'h3F, 6'h3E}  // R3 R7 address wrap
  };

  logic        clk;
  logic        rst_n;
  logic        cols80, attr_off, tiles512;
  logic [5:0]  map_base, tile_base;
  logic [7:0]  def_attr;
  logic [9:0]  scroll_x;
  logic [7:0]  scroll_y;
  logic        trans_we;
  logic [3:0]  trans_wdata;
  logic        pix_valid;
  logic [9:0]  pix_x;
  logic [7:0]  pix_y;
  logic        map_rd, pat_rd;
  logic [13:0] map_addr, pat_addr;
  logic [15:0] map_data;
  logic [7:0]  pat_data;
  logic        out_valid, out_transparent, out_below;
  logic [7:0]  out_index;

  int n_checks = 0;
  int n_fail   = 0;
  logic [3:0] cur_ti = 4'hF;

  tilemap_pixel_gen uut (
    .clk(clk), .rst_n(rst_n), .cols80(cols80), .attr_off(attr_off), .tiles512(tiles512),
    .map_base(map_base), .tile_base(tile_base), .def_attr(def_attr),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .trans_we(trans_we), .trans_wdata(trans_wdata),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .map_rd(map_rd), .map_addr(map_addr), .map_data(map_data),
    .pat_rd(pat_rd), .pat_addr(pat_addr), .pat_data(pat_data),
    .out_valid(out_valid), .out_index(out_index),
    .out_transparent(out_transparent), .out_below(out_below)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] mbyte(input int a);
    int b;
    b = a & 16383;
    b = (b * 37 + (b >> 7) * 13 + 5) & 255;
    return 8'(b);
  endfunction

  // Memory model: one cycle read latency on both ports.
  always @(posedge clk) begin
    if (map_rd) map_data <= {mbyte(int'(map_addr) + 1), mbyte(int'(map_addr))};
    if (pat_rd) pat_data <= mbyte(int'(pat_addr));
  end

  function automatic int ref_map_addr(input vec_t v);
    int w, sx, sy, ncol, ent;
    w    = v.c80 ? 640 : 320;
    ncol = v.c80 ? 80 : 40;
    sx   = (int'(v.x) + int'(v.ox)) % w;
    sy   = (int'(v.y) + int'(v.oy)) % 256;
    ent  = (sy / 8) * ncol + (sx / 8);
    return (int'(v.mb) * 256 + ent * (v.noat ? 1 : 2)) % 16384;
  endfunction

  // Returns {below, transparent, palette index}.
  function automatic logic [9:0] ref_pixel(input vec_t v, input logic [3:0] ti);
    int w, sx, sy, ma, tile, ix, iy, t, pa;
    logic [7:0] at, b;
    logic [3:0] nib;
    logic below;
    w  = v.c80 ? 640 : 320;
    sx = (int'(v.x) + int'(v.ox)) % w;
    sy = (int'(v.y) + int'(v.oy)) % 256;
    ma = ref_map_addr(v);
    at = v.noat ? v.dat : mbyte(ma + 1);
    tile  = int'(mbyte(ma)) + ((v.t512 && at[0]) ? 256 : 0);
    below = !v.t512 && at[0];
    ix = sx % 8;
    iy = sy % 8;
    if (at[1]) begin t = ix; ix = iy; iy = t; end
    if (at[3]) ix = 7 - ix;
    if (at[2]) iy = 7 - iy;
    pa  = (int'(v.tb) * 256 + tile * 32 + iy * 4 + ix / 2) % 16384;
    b   = mbyte(pa);
    nib = (ix % 2 == 0) ? b[7:4] : b[3:0];
    return {below, nib == ti, at[7:4], nib};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cols80 = v.c80; attr_off = v.noat; tiles512 = v.t512; def_attr = v.dat;
    map_base = v.mb; tile_base = v.tb; scroll_x = v.ox; scroll_y = v.oy;
    pix_x = v.x; pix_y = v.y; pix_valid = 1'b1;
  endtask

  task automatic run_one(input vec_t v, input string tag);
    logic [9:0] e;
    int ma;
    e  = ref_pixel(v, cur_ti);
    ma = ref_map_addr(v);
    @(negedge clk);
    apply(v);
    #1;
    check(map_addr == 14'(ma), "R3", {tag, " map_addr"}, int'(map_addr), ma);
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", {tag, " early valid"}, int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", {tag, " valid"}, int'(out_valid), 1);
    check(out_index == e[7:0], "R7 R8 R9", {tag, " index"}, int'(out_index), int'(e[7:0]));
    check(out_transparent == e[8], "R10", {tag, " transparent"}, int'(out_transparent), int'(e[8]));
    check(out_below == e[9], "R6", {tag, " below"}, int'(out_below), int'(e[9]));
  endtask

  task automatic write_trans(input logic [3:0] val);
    @(negedge clk);
    trans_we = 1'b1; trans_wdata = val;
    @(negedge clk);
    trans_we = 1'b0;
    cur_ti = val;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    vec_t v;
    logic [9:0] stream_exp [8];
    rst_n = 1'b0; pix_valid = 1'b0; trans_we = 1'b0; trans_wdata = 4'h0;
    map_data = '0; pat_data = '0;
    apply(VECS[0]); pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);

    // R1 reset value of the transparent index: find a pixel whose value is 0xF.
    begin
      bit found = 0;
      for (int x = 0; x < 320 && !found; x++) begin
        v = VECS[0];
        v.x = 10'(x);
        if (ref_pixel(v, 4'hF) ~^ 10'b0 == 10'b0) begin end
        if (ref_pixel(v, 4'hF) [3:0] == 4'hF) found = 1;
      end
      check(found, "R1", "pattern search", int'(found), 1);
      run_one(v, "R1 reset index");
      check(out_transparent == 1'b1, "R1", "reset index 0xF", int'(out_transparent), 1);
    end

    // Stimulus table walk.
    for (int i = 0; i < NVEC; i++) begin
      run_one(VECS[i], $sformatf("vec%0d", i));
    end

    // R2 back-to-back pixels on one configuration.
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check(out_valid == 1'b1, "R2", $sformatf("stream valid %0d", i - 3), int'(out_valid), 1);
        check(out_index == stream_exp[i-3][7:0], "R2", $sformatf("stream index %0d", i - 3),
              int'(out_index), int'(stream_exp[i-3][7:0]));
      end
      if (i < 8) begin
        v = VECS[7];
        v.x = 10'(60 + i * 3);
        v.y = 8'(17 + i);
        stream_exp[i] = ref_pixel(v, cur_ti);
        apply(v);
      end else begin
        pix_valid = 1'b0;
      end
    end

    // R10 loading the transparent index.
    v = VECS[3];
    write_trans(ref_pixel(v, 4'h0)[3:0]);
    run_one(v, "R10 loaded match");
    check(out_transparent == 1'b1, "R10", "loaded index match", int'(out_transparent), 1);
    write_trans(ref_pixel(v, 4'h0)[3:0] + 4'h1);
    run_one(v, "R10 loaded miss");
    check(out_transparent == 1'b0, "R10", "loaded index miss", int'(out_transparent), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule